// File: doc/BRIEF.md
# Amplitude Defect Detector with Hysteresis

The block watches a stream of signed, digitised RF samples for dropouts such as a scratch or a dark spot on a disc. Two envelope followers run side by side. One tracks the upper envelope and the other the lower envelope. Each follower jumps to a sample at once when that sample lies outside the value it holds. Otherwise it relaxes toward the sample by a programmable fraction of the gap. The amplitude is the upper envelope minus the lower envelope.

A defect flag is raised when the amplitude falls below a low threshold. It is dropped only once the amplitude climbs above a separate high threshold, which keeps the flag from chattering on a noisy edge. A one-cycle pulse marks every new rise of the flag so that it can feed an interrupt line. The envelopes and the amplitude are brought out so that software or a gain loop can observe them.

Top module: `amp_defect_det`

## Requirements
- R1: While reset is held and in the first cycle after it, both envelopes and the amplitude read 0, and `defect` and `defectRise` are low.
- R2: An accepted sample (`sampleValid` high) that is greater than or equal to `posEnv` replaces `posEnv` at the next clock edge. An accepted sample that is less than or equal to `negEnv` replaces `negEnv` at the next clock edge.
- R3: An accepted sample below `posEnv` sets `posEnv` to `posEnv - ((posEnv - sample) >> decayShift)` at the next edge, where the shift is a logical right shift of the non-negative gap.
- R4: An accepted sample above `negEnv` sets `negEnv` to `negEnv + ((sample - negEnv) >> decayShift)` at the next edge. `decayShift` = 0 therefore makes both envelopes follow the sample exactly.
- R5: `amplitude` equals `posEnv - negEnv` as an unsigned value one bit wider than a sample. It is valid in the same cycle as the envelopes, and `posEnv` is never below `negEnv`.
- R6: In a cycle with `sampleValid` low, the envelopes do not change, whatever is on `sample`.
- R7: In the cycle after an envelope update, an amplitude strictly below `thrLow` sets `defect` at the following edge.
- R8: When the amplitude is not below `thrLow`, an amplitude strictly above `thrHigh` clears `defect`. An amplitude within [`thrLow`, `thrHigh`] leaves `defect` unchanged.
- R9: When the thresholds are inverted and both conditions hold at once, setting wins over clearing.
- R10: `defectRise` is high for exactly the first cycle in which `defect` is high after being low. It stays low while `defect` remains high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Sample strobe |
| sample | input | SAMPLE_W | Signed RF sample |
| decayShift | input | SHIFT_W | Decay shift k for both followers |
| thrLow | input | SAMPLE_W+1 | Amplitude that sets the flag |
| thrHigh | input | SAMPLE_W+1 | Amplitude that clears the flag |
| posEnv | output | SAMPLE_W | Upper envelope, signed |
| negEnv | output | SAMPLE_W | Lower envelope, signed |
| amplitude | output | SAMPLE_W+1 | Envelope difference, unsigned |
| defect | output | 1 | Dropout flag |
| defectRise | output | 1 | One-cycle pulse on a new dropout |

## Verification
A wrong follower state shows on `posEnv` or `negEnv` in the cycle after the offending sample. Because the decay recurses on the held value, the error persists and grows visible through `amplitude` in that same cycle. A fault in the hysteresis state appears on `defect` one cycle later, and it stays wrong until a threshold crossing forces the flag. Sequences are therefore chosen so that each crossing, each hold band and the inverted-threshold case are followed by several further samples. The long decay sequences also expose a stale envelope.

// File: rtl/amp_defect_pkg.sv
package amp_defect_pkg;
  typedef struct packed {
    logic envUpdate;
    logic flagEval;
  } ctrlStrobes_t;
endpackage

// File: rtl/env_follower.sv
module env_follower #(
  parameter int SAMPLE_W = 8,
  parameter int SHIFT_W  = 3,
  parameter bit TRACK_MAX = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                update,
  input  logic [SAMPLE_W-1:0] x,
  input  logic [SHIFT_W-1:0]  shiftK,
  output logic [SAMPLE_W-1:0] held
);
  localparam int EXT_W = SAMPLE_W + 1;

  logic signed [EXT_W-1:0] xExt, heldExt, gap, nextExt;
  logic        [EXT_W-1:0] step;
  logic                    attack;

  assign xExt    = {x[SAMPLE_W-1], x};
  assign heldExt = {held[SAMPLE_W-1], held};

  generate
    if (TRACK_MAX) begin : g_max
      assign gap     = heldExt - xExt;
      assign nextExt = heldExt - $signed(step);
    end else begin : g_min
      assign gap     = xExt - heldExt;
      assign nextExt = heldExt + $signed(step);
    end
  endgenerate

  assign attack = gap[EXT_W-1] || (gap == '0);
  assign step   = $unsigned(gap) >> shiftK;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      held <= '0;
    end else if (update) begin
      held <= attack ? x : nextExt[SAMPLE_W-1:0];
    end
  end
endmodule

// File: rtl/amp_defect_datapath.sv
module amp_defect_datapath
  import amp_defect_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int SHIFT_W  = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [SHIFT_W-1:0]  decayShift,
  output logic [SAMPLE_W-1:0] posEnv,
  output logic [SAMPLE_W-1:0] negEnv,
  output logic [SAMPLE_W:0]   amplitude
);
  env_follower #(.SAMPLE_W(SAMPLE_W), .SHIFT_W(SHIFT_W), .TRACK_MAX(1'b1)) i_posFollower (
    .clk(clk), .rstN(rstN), .update(strobes.envUpdate),
    .x(sample), .shiftK(decayShift), .held(posEnv)
  );

  env_follower #(.SAMPLE_W(SAMPLE_W), .SHIFT_W(SHIFT_W), .TRACK_MAX(1'b0)) i_negFollower (
    .clk(clk), .rstN(rstN), .update(strobes.envUpdate),
    .x(sample), .shiftK(decayShift), .held(negEnv)
  );

  assign amplitude = {posEnv[SAMPLE_W-1], posEnv} - {negEnv[SAMPLE_W-1], negEnv};
endmodule

// File: rtl/amp_defect_ctrl.sv
module amp_defect_ctrl
  import amp_defect_pkg::*;
#(
  parameter int AMP_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic [AMP_W-1:0] amplitude,
  input  logic [AMP_W-1:0] thrLow,
  input  logic [AMP_W-1:0] thrHigh,
  output ctrlStrobes_t     strobes,
  output logic             defect,
  output logic             defectRise
);
  logic evalPending;
  logic belowLow, aboveHigh, nextDefect;

  always_ff @(posedge clk) begin
    if (!rstN) evalPending <= 1'b0;
    else       evalPending <= sampleValid;
  end

  always_comb begin
    strobes.envUpdate = sampleValid;
    strobes.flagEval  = evalPending;
  end

  assign belowLow  = amplitude < thrLow;
  assign aboveHigh = amplitude > thrHigh;

  always_comb begin
    nextDefect = defect;
    if (strobes.flagEval) begin
      if (belowLow)       nextDefect = 1'b1;
      else if (aboveHigh) nextDefect = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      defect     <= 1'b0;
      defectRise <= 1'b0;
    end else begin
      defect     <= nextDefect;
      defectRise <= nextDefect && !defect;
    end
  end
endmodule

// File: rtl/amp_defect_det.sv
module amp_defect_det
  import amp_defect_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int SHIFT_W  = 3,
  localparam int AMP_W   = SAMPLE_W + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [SHIFT_W-1:0]  decayShift,
  input  logic [AMP_W-1:0]    thrLow,
  input  logic [AMP_W-1:0]    thrHigh,
  output logic [SAMPLE_W-1:0] posEnv,
  output logic [SAMPLE_W-1:0] negEnv,
  output logic [AMP_W-1:0]    amplitude,
  output logic                defect,
  output logic                defectRise
);
  ctrlStrobes_t strobes;

  amp_defect_ctrl #(.AMP_W(AMP_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .amplitude(amplitude),
    .thrLow(thrLow), .thrHigh(thrHigh), .strobes(strobes),
    .defect(defect), .defectRise(defectRise)
  );

  amp_defect_datapath #(.SAMPLE_W(SAMPLE_W), .SHIFT_W(SHIFT_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sample(sample),
    .decayShift(decayShift), .posEnv(posEnv), .negEnv(negEnv), .amplitude(amplitude)
  );
endmodule

// File: rtl/amp_defect_chk.sv
module amp_defect_chk #(
  parameter int SAMPLE_W = 8,
  parameter int SHIFT_W  = 3,
  localparam int AMP_W   = SAMPLE_W + 1
) (
  input logic                clk,
  input logic                rstN,
  input logic                sampleValid,
  input logic [SAMPLE_W-1:0] sample,
  input logic [SHIFT_W-1:0]  decayShift,
  input logic [AMP_W-1:0]    thrLow,
  input logic [AMP_W-1:0]    thrHigh,
  input logic [SAMPLE_W-1:0] posEnv,
  input logic [SAMPLE_W-1:0] negEnv,
  input logic [AMP_W-1:0]    amplitude,
  input logic                defect,
  input logic                defectRise
);
  // R2
  pos_attack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && ($signed(sample) >= $signed(posEnv))) |=> (posEnv == $past(sample)));

  // R2
  neg_attack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && ($signed(sample) <= $signed(negEnv))) |=> (negEnv == $past(sample)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> ($stable(posEnv) && $stable(negEnv)));

  // R5
  env_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    $signed(posEnv) >= $signed(negEnv));

  // R10
  rise_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    defectRise |-> defect);

  // R10
  rise_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(defect) |-> defectRise);

  // R10
  rise_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    defectRise |=> !defectRise);
endmodule

bind amp_defect_det amp_defect_chk #(.SAMPLE_W(SAMPLE_W), .SHIFT_W(SHIFT_W)) i_amp_defect_chk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sample(sample),
  .decayShift(decayShift), .thrLow(thrLow), .thrHigh(thrHigh), .posEnv(posEnv),
  .negEnv(negEnv), .amplitude(amplitude), .defect(defect), .defectRise(defectRise)
);

// File: tb/test_amp_defect_det.sv
module test_amp_defect_det;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 8;
  localparam int KW = 3;
  localparam int AW = SW + 1;

  typedef struct {
    int    pos;
    int    neg;
    int    amp;
    bit    flag;
    bit    rise;
    string posTag;
    string negTag;
    string flagTag;
  } expItem_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sampleValid = 1'b0;
  logic [SW-1:0] sample = '0;
  logic [KW-1:0] decayShift = '0;
  logic [AW-1:0] thrLow = '0;
  logic [AW-1:0] thrHigh = '0;
  logic [SW-1:0] posEnv, negEnv;
  logic [AW-1:0] amplitude;
  logic          defect, defectRise;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  expItem_t expQ[$];

  int  mPos = 0, mNeg = 0;
  bit  mFlag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  amp_defect_det i_amp_defect_det (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sample(sample),
    .decayShift(decayShift), .thrLow(thrLow), .thrHigh(thrHigh), .posEnv(posEnv),
    .negEnv(negEnv), .amplitude(amplitude), .defect(defect), .defectRise(defectRise)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Driver: applies one sample, builds the expectation from the requirements.
  task automatic applySample(input int x);
    expItem_t it;
    int k, amp;
    bit prev;
    k = int'(decayShift);
    @(negedge clk);
    sampleValid = 1'b1;
    sample = x[SW-1:0];
    @(negedge clk);
    sampleValid = 1'b0;
    sample = 8'h5a;
    if (x >= mPos) begin mPos = x; it.posTag = "R2 posEnv"; end
    else begin mPos = mPos - ((mPos - x) >> k); it.posTag = "R3 posEnv"; end
    if (x <= mNeg) begin mNeg = x; it.negTag = "R2 negEnv"; end
    else begin mNeg = mNeg + ((x - mNeg) >> k); it.negTag = "R4 negEnv"; end
    amp = mPos - mNeg;
    prev = mFlag;
    if (amp < int'(thrLow) && amp > int'(thrHigh)) begin mFlag = 1; it.flagTag = "R9 defect"; end
    else if (amp < int'(thrLow)) begin mFlag = 1; it.flagTag = "R7 defect"; end
    else if (amp > int'(thrHigh)) begin mFlag = 0; it.flagTag = "R8 defect clear"; end
    else it.flagTag = "R8 defect hold";
    it.pos = mPos; it.neg = mNeg; it.amp = amp;
    it.flag = mFlag; it.rise = mFlag && !prev;
    @(negedge clk);
    expQ.push_back(it);
  endtask

  // Monitor: compares outputs when an expectation is due.
  initial begin
    expItem_t it;
    forever begin
      wait (expQ.size() > 0);
      it = expQ.pop_front();
      check(it.posTag, int'($signed(posEnv)), it.pos);
      check(it.negTag, int'($signed(negEnv)), it.neg);
      check("R5 amplitude", int'(amplitude), it.amp);
      check(it.flagTag, int'(defect), int'(it.flag));
      check("R10 defectRise", int'(defectRise), int'(it.rise));
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 posEnv reset", int'(posEnv), 0);
    check("R1 negEnv reset", int'(negEnv), 0);
    check("R1 defect reset", int'(defect), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 amplitude after reset", int'(amplitude), 0);
    check("R1 defectRise after reset", int'(defectRise), 0);

    decayShift = 3'd2; thrLow = 9'd20; thrHigh = 9'd60;
    applySample(100);
    for (int i = 0; i < 6; i++) begin applySample(90); applySample(-90); end
    for (int i = 0; i < 20; i++) applySample(0);
    applySample(25); applySample(-15);
    applySample(30); applySample(-30);
    for (int i = 0; i < 3; i++) begin applySample(120); applySample(-110); end

    // R6: idle cycles with sample changing must not move the envelopes
    begin
      int p0, n0;
      p0 = int'($signed(posEnv)); n0 = int'($signed(negEnv));
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        sample = 8'(i * 53 - 128);
      end
      check("R6 posEnv idle", int'($signed(posEnv)), p0);
      check("R6 negEnv idle", int'($signed(negEnv)), n0);
    end

    decayShift = 3'd0;
    applySample(10); applySample(10); applySample(-40); applySample(60);
    decayShift = 3'd7;
    applySample(127); applySample(-128); applySample(0); applySample(5);
    decayShift = 3'd1;
    for (int i = 0; i < 10; i++) applySample(3);

    thrLow = 9'd80; thrHigh = 9'd40;
    applySample(70); applySample(-20);
    applySample(50); applySample(-45);
    applySample(0);
    for (int i = 0; i < 4; i++) begin applySample(60); applySample(-60); end
    applySample(40); applySample(-40);

    wait (expQ.size() == 0);
    @(negedge clk);
    finish();
  end
endmodule